// File: doc/BRIEF.md
# Shared-Period Multi-Output PWM Timer

This block is a pulse-width generator built on a counter that a programmable prescaler drives. A bank of compare registers watches the counter. Register 0 fixes the length of a cycle, and every output uses that same cycle. The other registers place the edges of up to six outputs. Each output from the second onward can run in one of two modes. In single-edge mode the pulse starts at the cycle boundary. In two-edge mode both edges sit anywhere in the cycle, so a pulse can be positive-going or negative-going.

Software programs the block through a flat word-wide register port. When the PWM mode is on, new compare values land in shadow copies. Each shadow is moved into use only after software releases it through a latch-enable mask, and the move happens at the next cycle boundary, so no output ever sees a mix of old and new edges. With the PWM mode off, the outputs stay low and the block serves as a plain timer. Each compare register can request an interrupt, a counter reset or a counter stop.

Top module: `mpwm_unit`

## Requirements
- R1: After reset, every register reads 0, all outputs are low and `irq` is low.
- R2: The prescale counter (read-only, address 0x2) counts from 0 up to the limit at address 0x1 and then wraps. The timer count (read/write, address 0x3) advances once for every limit+1 enabled clock cycles. A write to address 0x3 loads the count.
- R3: Control word at address 0x0. Bit 0 runs the counters, bit 1 holds both counters at 0 while it is set, and bit 2 turns on the PWM mode.
- R4: The action word at address 0x4 holds three bits for each compare register k: bit 3k requests an interrupt, bit 3k+1 resets the counter and bit 3k+2 stops it. A stop match clears control bit 0 and leaves the count at the matched value.
- R5: A reset match makes the count read 0 on the next prescaler tick after it equals the compare value. The count therefore runs through the range 0..value.
- R6: The interrupt flags at address 0x7 (bit k for compare register k) are sticky. Writing 1 clears a flag and writing 0 has no effect. `irq` is high whenever any flag is set.
- R7: With the PWM mode off, a write to a compare register (address 0x8+k) takes effect at once, and all outputs are held low.
- R8: Single-edge output n (bit n-1 of `pwm_out`) rises at the compare-0 match and falls at the compare-n match. With compare 0 = P as a reset match, the output is high for Mn+1 of every P+1 counts. If Mn > P, it stays high for the whole cycle.
- R9: Bit n of the mode word at address 0x5 (n = 2..6) puts output n in two-edge mode. Compare n-1 (value a) sets the output and compare n (value b) clears it. The output is high for b-a counts when a < b, and for P+1-(a-b) counts when a > b.
- R10: In PWM mode a write goes to the shadow of a compare register and is read back from there. Setting bit k at the latch address 0x6 releases shadow k. Released values take effect at the next compare-0 reset match, and the latch bits then read 0.
- R11: If the set match and the clear match of an output fall on the same count, the output goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | N_MATCH-1 (6) | PWM outputs; bit n-1 is output n |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The assertions check the following on every cycle:
- the count moves only on a tick, a load or a hold;
- a reset match gives zero;
- a stop match drops the run bit and freezes the count;
- flags stay set until cleared;
- compare values change only on a release or a direct write;
- the latch mask empties after a release;
- a clear event always leaves its output low;
- outputs are idle while the PWM mode is off.

Only the bench scenarios can show the actual pulse widths: single-edge, positive and negative two-edge, a compare beyond the period, and coincident edges. They also show that an unreleased shadow leaves the waveform unchanged, and that the prescaler divides the count rate.

// File: rtl/mpwm_pkg.sv
`timescale 1ns/1ps
package mpwm_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned REG_DW = 32;

  // register word addresses
  localparam logic [REG_AW-1:0] A_CTRL   = 5'd0;
  localparam logic [REG_AW-1:0] A_PLIM   = 5'd1;
  localparam logic [REG_AW-1:0] A_PCNT   = 5'd2;
  localparam logic [REG_AW-1:0] A_TCNT   = 5'd3;
  localparam logic [REG_AW-1:0] A_MCTL   = 5'd4;
  localparam logic [REG_AW-1:0] A_OMODE  = 5'd5;
  localparam logic [REG_AW-1:0] A_LATCH  = 5'd6;
  localparam logic [REG_AW-1:0] A_IFLAG  = 5'd7;
  localparam logic [REG_AW-1:0] A_MATCH0 = 5'd8;

  // control word bits
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_HOLD = 1;
  localparam int unsigned CB_PWM  = 2;

  // offsets inside one three-bit action group
  localparam int unsigned MC_IRQ  = 0;
  localparam int unsigned MC_RST  = 1;
  localparam int unsigned MC_STOP = 2;

  // next level of a PWM output: clear beats set, otherwise hold
  function automatic logic edge_next(input logic cur, input logic set_ev,
                                     input logic clr_ev);
    if (clr_ev) return 1'b0;
    if (set_ev) return 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/mpwm_timebase.sv
`timescale 1ns/1ps
module mpwm_timebase #(
  parameter int unsigned PS_W = 32,
  parameter int unsigned TC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            hold,
  input  logic [PS_W-1:0] plim,
  input  logic            tc_wr,
  input  logic [TC_W-1:0] tc_wdata,
  input  logic            cnt_rst,
  input  logic            cnt_stop,
  output logic            tick,
  output logic [PS_W-1:0] pc,
  output logic [TC_W-1:0] tc
);
  function automatic logic [PS_W-1:0] ps_step(input logic [PS_W-1:0] cur,
                                              input logic [PS_W-1:0] lim);
    return (cur >= lim) ? '0 : cur + PS_W'(1);
  endfunction

  function automatic logic [TC_W-1:0] tc_step(input logic [TC_W-1:0] cur,
                                              input logic do_rst,
                                              input logic do_stop);
    if (do_rst)  return '0;
    if (do_stop) return cur;
    return cur + TC_W'(1);
  endfunction

  assign tick = run && !hold && (pc >= plim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      tc <= '0;
    end else if (hold) begin
      pc <= '0;
      tc <= '0;
    end else begin
      if (run) pc <= ps_step(pc, plim);
      if (tc_wr)     tc <= tc_wdata;
      else if (tick) tc <= tc_step(tc, cnt_rst, cnt_stop);
    end
  end
endmodule

// File: rtl/mpwm_match_bank.sv
`timescale 1ns/1ps
module mpwm_match_bank #(
  parameter int unsigned TC_W    = 32,
  parameter int unsigned N_MATCH = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_MATCH-1:0]              m_wr,
  input  logic [TC_W-1:0]                 wdata,
  input  logic                            direct,
  input  logic [N_MATCH-1:0]              latch_set,
  input  logic                            release_ev,
  input  logic [TC_W-1:0]                 tc,
  input  logic                            tick,
  output logic [N_MATCH-1:0][TC_W-1:0]    shadow,
  output logic [N_MATCH-1:0][TC_W-1:0]    act,
  output logic [N_MATCH-1:0]              pend,
  output logic [N_MATCH-1:0]              hit
);
  function automatic logic is_match(input logic en, input logic [TC_W-1:0] cnt,
                                    input logic [TC_W-1:0] ref_v);
    return en && (cnt == ref_v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      act    <= '0;
    end else begin
      for (int k = 0; k < N_MATCH; k++) begin
        if (m_wr[k]) shadow[k] <= wdata;
        if (m_wr[k] && direct)          act[k] <= wdata;
        else if (release_ev && pend[k]) act[k] <= shadow[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (release_ev ? '0 : pend) | latch_set;
  end

  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
    assign hit[k] = is_match(tick, tc, act[k]);
  end
endmodule

// File: rtl/mpwm_out_chan.sv
`timescale 1ns/1ps
module mpwm_out_chan
  import mpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic set_ev,
  input  logic clr_ev,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (!active) q <= 1'b0;
    else              q <= edge_next(q, set_ev, clr_ev);
  end
endmodule

// File: rtl/mpwm_unit.sv
`timescale 1ns/1ps
module mpwm_unit
  import mpwm_pkg::*;
#(
  parameter int unsigned TC_W    = 32,
  parameter int unsigned PS_W    = 32,
  parameter int unsigned N_MATCH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic [N_MATCH-2:0] pwm_out,
  output logic              irq
);
  localparam int unsigned N_OUT = N_MATCH - 1;
  localparam int unsigned MC_W  = 3 * N_MATCH;

  // programmed state
  logic                 ctrl_en, ctrl_hold, ctrl_pwm;
  logic [PS_W-1:0]      plim;
  logic [MC_W-1:0]      mctl;
  logic [N_OUT:2]       dbl;
  logic [N_MATCH-1:0]   flags;

  // write decode
  logic ctrl_wr, plim_wr, tc_wr, mctl_wr, mode_wr, latch_wr, flag_wr;
  logic [N_MATCH-1:0] m_wr, latch_set, flag_clr;

  // counter and compare events
  logic                          tick;
  logic [PS_W-1:0]               pc;
  logic [TC_W-1:0]               tc;
  logic [N_MATCH-1:0][TC_W-1:0]  shadow, act;
  logic [N_MATCH-1:0]            pend, hit;
  logic [N_MATCH-1:0]            irq_hit, rst_hit, stop_hit;
  logic                          rst_any, stop_any, release_ev, direct_wr;
  logic [N_OUT-1:0]              set_ev, clr_ev;

  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign plim_wr  = reg_wr && (reg_addr == A_PLIM);
  assign tc_wr    = reg_wr && (reg_addr == A_TCNT);
  assign mctl_wr  = reg_wr && (reg_addr == A_MCTL);
  assign mode_wr  = reg_wr && (reg_addr == A_OMODE);
  assign latch_wr = reg_wr && (reg_addr == A_LATCH);
  assign flag_wr  = reg_wr && (reg_addr == A_IFLAG);

  assign latch_set = latch_wr ? reg_wdata[N_MATCH-1:0] : '0;
  assign flag_clr  = flag_wr  ? reg_wdata[N_MATCH-1:0] : '0;

  for (genvar k = 0; k < N_MATCH; k++) begin : g_mdec
    assign m_wr[k]     = reg_wr && (reg_addr == A_MATCH0 + REG_AW'(k));
    assign irq_hit[k]  = hit[k] && mctl[3*k + MC_IRQ];
    assign rst_hit[k]  = hit[k] && mctl[3*k + MC_RST];
    assign stop_hit[k] = hit[k] && mctl[3*k + MC_STOP];
  end

  assign rst_any    = |rst_hit;
  assign stop_any   = |stop_hit;
  assign release_ev = ctrl_pwm && rst_hit[0];
  assign direct_wr  = !ctrl_pwm && (|m_wr);

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_hold <= 1'b0;
      ctrl_pwm  <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_en   <= reg_wdata[CB_EN];
      ctrl_hold <= reg_wdata[CB_HOLD];
      ctrl_pwm  <= reg_wdata[CB_PWM];
    end else if (stop_any) begin
      ctrl_en   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plim <= '0;
      mctl <= '0;
      dbl  <= '0;
    end else begin
      if (plim_wr) plim <= reg_wdata[PS_W-1:0];
      if (mctl_wr) mctl <= reg_wdata[MC_W-1:0];
      if (mode_wr) dbl  <= reg_wdata[N_OUT:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | irq_hit;
  end

  assign irq = |flags;

  mpwm_timebase #(.PS_W(PS_W), .TC_W(TC_W)) i_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_en),
    .hold     (ctrl_hold),
    .plim     (plim),
    .tc_wr    (tc_wr),
    .tc_wdata (reg_wdata[TC_W-1:0]),
    .cnt_rst  (rst_any),
    .cnt_stop (stop_any),
    .tick     (tick),
    .pc       (pc),
    .tc       (tc)
  );

  mpwm_match_bank #(.TC_W(TC_W), .N_MATCH(N_MATCH)) i_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_wr       (m_wr),
    .wdata      (reg_wdata[TC_W-1:0]),
    .direct     (!ctrl_pwm),
    .latch_set  (latch_set),
    .release_ev (release_ev),
    .tc         (tc),
    .tick       (tick),
    .shadow     (shadow),
    .act        (act),
    .pend       (pend),
    .hit        (hit)
  );

  // outputs: output 1 is single-edge only, the rest follow their mode bit
  for (genvar n = 1; n <= N_OUT; n++) begin : g_out
    if (n == 1) begin : g_single
      assign set_ev[n-1] = hit[0];
    end else begin : g_mixed
      assign set_ev[n-1] = dbl[n] ? hit[n-1] : hit[0];
    end
    assign clr_ev[n-1] = hit[n];

    mpwm_out_chan i_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (ctrl_pwm),
      .set_ev (set_ev[n-1]),
      .clr_ev (clr_ev[n-1]),
      .q      (pwm_out[n-1])
    );
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CB_EN]   = ctrl_en;
        reg_rdata[CB_HOLD] = ctrl_hold;
        reg_rdata[CB_PWM]  = ctrl_pwm;
      end
      A_PLIM:  reg_rdata[PS_W-1:0]    = plim;
      A_PCNT:  reg_rdata[PS_W-1:0]    = pc;
      A_TCNT:  reg_rdata[TC_W-1:0]    = tc;
      A_MCTL:  reg_rdata[MC_W-1:0]    = mctl;
      A_OMODE: reg_rdata[N_OUT:2]     = dbl;
      A_LATCH: reg_rdata[N_MATCH-1:0] = pend;
      A_IFLAG: reg_rdata[N_MATCH-1:0] = flags;
      default: begin
        for (int k = 0; k < N_MATCH; k++) begin
          if (reg_addr == A_MATCH0 + REG_AW'(k)) reg_rdata[TC_W-1:0] = shadow[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/mpwm_checker.sv
`timescale 1ns/1ps
module mpwm_checker #(
  parameter int unsigned TC_W    = 32,
  parameter int unsigned N_MATCH = 7
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick,
  input logic                         tc_wr,
  input logic                         hold,
  input logic [TC_W-1:0]              tc,
  input logic                         rst_any,
  input logic                         stop_any,
  input logic                         ctrl_wr,
  input logic                         ctrl_en,
  input logic                         pwm_mode,
  input logic [N_MATCH-2:0]           pwm_out,
  input logic [N_MATCH-2:0]           clr_ev,
  input logic                         release_ev,
  input logic                         direct_wr,
  input logic                         latch_wr,
  input logic [N_MATCH-1:0][TC_W-1:0] act,
  input logic [N_MATCH-1:0]           pend,
  input logic [N_MATCH-1:0]           flags,
  input logic [N_MATCH-1:0]           flag_clr
);
  // R2: the count moves only on a tick, a load or a hold
  a_r2_count_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !tc_wr && !hold) |=> $stable(tc));

  // R5: a reset match brings the count to zero
  a_r5_reset_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_any && !tc_wr && !hold) |=> (tc == '0));

  // R4: a stop match drops the run bit
  a_r4_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_any && !ctrl_wr) |=> !ctrl_en);

  // R4: a stop match without reset freezes the count
  a_r4_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_any && !rst_any && !tc_wr && !hold) |=> $stable(tc));

  // R7: outputs idle while the PWM mode is off
  a_r7_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_mode |=> (pwm_out == '0));

  // R10: compare values change only on a release or a direct write
  a_r10_act_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !(release_ev || direct_wr) |=> $stable(act));

  // R10: the latch mask empties after a release
  a_r10_latch_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (release_ev && !latch_wr) |=> (pend == '0));

  for (genvar j = 0; j < N_MATCH - 1; j++) begin : g_outchk
    // R11: a clear event leaves the output low, even with a set
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ev[j] |=> !pwm_out[j]);
  end

  for (genvar k = 0; k < N_MATCH; k++) begin : g_flagchk
    // R6: a flag stays set until a 1 is written to it
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[k] && !flag_clr[k]) |=> flags[k]);
  end
endmodule

bind mpwm_unit mpwm_checker #(.TC_W(TC_W), .N_MATCH(N_MATCH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .tc_wr      (tc_wr),
  .hold       (ctrl_hold),
  .tc         (tc),
  .rst_any    (rst_any),
  .stop_any   (stop_any),
  .ctrl_wr    (ctrl_wr),
  .ctrl_en    (ctrl_en),
  .pwm_mode   (ctrl_pwm),
  .pwm_out    (pwm_out),
  .clr_ev     (clr_ev),
  .release_ev (release_ev),
  .direct_wr  (direct_wr),
  .latch_wr   (latch_wr),
  .act        (act),
  .pend       (pend),
  .flags      (flags),
  .flag_clr   (flag_clr)
);

// File: tb/test_mpwm_unit.sv
`timescale 1ns/1ps
module test_mpwm_unit;
  import mpwm_pkg::*;

  localparam int unsigned N_MATCH = 7;
  localparam int unsigned N_OUT   = N_MATCH - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [REG_DW-1:0] reg_wdata = '0;
  logic [REG_DW-1:0] reg_rdata;
  logic [N_OUT-1:0]  pwm_out;
  logic              irq;

  mpwm_unit #(.TC_W(32), .PS_W(32), .N_MATCH(N_MATCH)) i_mpwm_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  always #4 clk = ~clk;

  // scoreboard
  typedef struct {
    string       tag;
    logic [31:0] exp;
  } sb_item_t;

  sb_item_t    sb_q[$];
  logic [31:0] obs;
  event        obs_ev;
  int          n_checks = 0;
  int          n_err = 0;
  bit          done = 1'b0;
  int          duty [N_OUT];

  initial begin : monitor
    sb_item_t it;
    forever begin
      @(obs_ev);
      it = sb_q.pop_front();
      n_checks++;
      if (obs !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual %0d expected %0d", it.tag, obs, it.exp);
      end
    end
  end

  task automatic expect_eq(input string tag, input logic [31:0] actual,
                           input logic [31:0] expected);
    sb_item_t it;
    it.tag = tag;
    it.exp = expected;
    sb_q.push_back(it);
    obs = actual;
    ->obs_ev;
    #1;
  endtask

  task automatic reg_write(input logic [REG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [REG_AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    reg_wr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic measure(input int cycles);
    for (int j = 0; j < N_OUT; j++) duty[j] = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #1;
      for (int j = 0; j < N_OUT; j++) if (pwm_out[j]) duty[j]++;
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin : driver
    logic [31:0] v, a, b;
    int mx, zeros;
    int exp_duty [N_OUT];

    // R1 reset state
    do_reset();
    reg_read(A_CTRL, v);  expect_eq("R1 ctrl after reset", v, 0);
    reg_read(A_TCNT, v);  expect_eq("R1 count after reset", v, 0);
    reg_read(A_IFLAG, v); expect_eq("R1 flags after reset", v, 0);
    reg_read(A_LATCH, v); expect_eq("R1 latch after reset", v, 0);
    expect_eq("R1 outputs after reset", 32'(pwm_out), 0);
    expect_eq("R1 irq after reset", 32'(irq), 0);

    // R2 counter load and prescale rate
    reg_write(A_TCNT, 100);
    reg_read(A_TCNT, v); expect_eq("R2 count load", v, 100);
    reg_write(A_TCNT, 0);
    reg_write(A_PLIM, 3);
    reg_write(A_CTRL, 32'h1);
    reg_read(A_TCNT, a);
    repeat (39) @(negedge clk);
    reg_read(A_TCNT, b);
    expect_eq("R2 count advance over 40 cycles", b - a, 10);
    mx = 0;
    for (int i = 0; i < 8; i++) begin
      reg_read(A_PCNT, v);
      if (int'(v) > mx) mx = int'(v);
    end
    expect_eq("R2 prescale peak", 32'(mx), 3);

    // R3 hold bit
    reg_write(A_CTRL, 32'h3);
    idle(3);
    reg_read(A_TCNT, v); expect_eq("R3 hold count", v, 0);
    reg_read(A_PCNT, v); expect_eq("R3 hold prescale", v, 0);

    // R4 stop action, R6 flags, R7 direct write in timer mode
    do_reset();
    reg_write(A_MATCH0 + 5'd1, 5);
    reg_write(A_MCTL, 32'h28);
    reg_write(A_CTRL, 32'h1);
    idle(20);
    reg_read(A_TCNT, v);  expect_eq("R4 R7 stop at direct compare", v, 5);
    reg_read(A_CTRL, v);  expect_eq("R4 run bit cleared", v, 0);
    reg_read(A_IFLAG, v); expect_eq("R6 flag set", v, 2);
    expect_eq("R6 irq high", 32'(irq), 1);
    reg_write(A_IFLAG, 0);
    reg_read(A_IFLAG, v); expect_eq("R6 zero write keeps flag", v, 2);
    reg_write(A_IFLAG, 2);
    reg_read(A_IFLAG, v); expect_eq("R6 flag cleared", v, 0);
    expect_eq("R6 irq low", 32'(irq), 0);

    // R5 reset action
    do_reset();
    reg_write(A_MATCH0 + 5'd2, 7);
    reg_write(A_MCTL, 32'h80);
    reg_write(A_CTRL, 32'h1);
    idle(10);
    mx = 0; zeros = 0;
    for (int i = 0; i < 40; i++) begin
      reg_read(A_TCNT, v);
      if (int'(v) > mx) mx = int'(v);
      if (v == 0) zeros++;
    end
    expect_eq("R5 count peak", 32'(mx), 7);
    expect_eq("R5 wraps in 40 cycles", 32'(zeros), 5);

    // R8 R9 PWM waveforms
    do_reset();
    reg_write(A_CTRL, 32'h4);
    reg_write(A_MATCH0 + 5'd0, 9);
    reg_write(A_MATCH0 + 5'd1, 3);
    reg_write(A_MATCH0 + 5'd2, 6);
    reg_write(A_MATCH0 + 5'd3, 12);
    reg_write(A_MATCH0 + 5'd4, 2);
    reg_write(A_MATCH0 + 5'd5, 7);
    reg_write(A_MATCH0 + 5'd6, 1);
    reg_read(A_MATCH0 + 5'd1, v); expect_eq("R10 shadow read", v, 3);
    reg_write(A_LATCH, 32'h7F);
    reg_read(A_LATCH, v); expect_eq("R10 latch pending", v, 32'h7F);
    reg_write(A_MCTL, 32'h2);
    reg_write(A_OMODE, 32'h60);
    reg_write(A_CTRL, 32'h5);
    idle(30);
    reg_read(A_LATCH, v); expect_eq("R10 latch self-clears", v, 0);
    measure(10);
    exp_duty = '{4, 7, 10, 3, 5, 4};
    for (int j = 0; j < N_OUT; j++)
      expect_eq($sformatf("R8 R9 out%0d high counts", j + 1), 32'(duty[j]), 32'(exp_duty[j]));

    // R10 unreleased shadow has no effect, then release
    reg_write(A_MATCH0 + 5'd1, 8);
    idle(30);
    measure(10);
    expect_eq("R10 unreleased out1", 32'(duty[0]), 4);
    reg_write(A_LATCH, 32'h02);
    idle(30);
    measure(10);
    expect_eq("R10 released out1", 32'(duty[0]), 9);

    // R11 coincident set and clear
    reg_write(A_MATCH0 + 5'd4, 7);
    reg_write(A_LATCH, 32'h10);
    idle(30);
    measure(10);
    expect_eq("R11 out5 coincident edges", 32'(duty[4]), 0);
    expect_eq("R8 out4 after update", 32'(duty[3]), 8);
    expect_eq("R9 out6 unchanged", 32'(duty[5]), 4);

    // R7 PWM off: outputs idle
    reg_write(A_CTRL, 32'h1);
    idle(5);
    measure(20);
    for (int j = 0; j < N_OUT; j++)
      expect_eq($sformatf("R7 out%0d idle", j + 1), 32'(duty[j]), 0);

    finish_up();
  end
endmodule